// File: doc/BRIEF.md
# IPv4 Header Checksum Verifier

This block checks the header checksum of a 20-byte IPv4 header that arrives one byte per accepted cycle, most significant byte of each 16-bit word first (network order). Bytes are paired into big-endian words. Each word is added into a ones' complement running sum, with the carry folded back into the low bits. When the twentieth byte has been taken, the folded sum is complemented. The block then raises a one-cycle result pulse that carries a pass/fail flag and the checksum field it found in the header.

A receive path drives a start strobe on the first header byte and a last strobe on the twentieth. The block is controlled by a small state machine with four states:
- `ST_IDLE`: waiting for a start byte.
- `ST_HI`: expecting the high byte of a word.
- `ST_LO`: expecting the low byte of a word.
- `ST_REPORT`: presenting the result.

Its transitions are:
- START: a start byte, from any state, goes to `ST_LO`. It goes to `ST_IDLE` instead if the last strobe is also set on that byte.
- PAIR_DONE: `ST_LO` goes to `ST_HI` on the low byte of a word that is not the last word.
- NEXT_PAIR: `ST_HI` goes to `ST_LO` on the next high byte.
- FINISH: `ST_LO` goes to `ST_REPORT` on the twentieth byte, when that byte carries the last strobe.
- ABANDON: `ST_HI` or `ST_LO` goes to `ST_IDLE` on a misplaced or missing last strobe.
- RELEASE: `ST_REPORT` goes to `ST_IDLE` after one cycle.

Top module: `ipv4_csum_verifier`

## Requirements
- R1: Byte pairs are assembled in network order: the first byte of each pair (even offset) is bits 15:8 of the word and the second byte is bits 7:0. A header whose checksum bytes are swapped therefore reports an error.
- R2: The ten words, the checksum word among them, are summed with end-around carry. `res_error` is 0 exactly when the bitwise complement of the folded sum is 0x0000. The words 4500 003c 1c46 4000 4017 c311 aca8 0101 aca8 0102 pass, and an all-zero header fails.
- R3: No carry is lost: the 17-bit accumulator never holds 0x1FFFF, and a header of twenty 0xFF bytes passes.
- R4: `res_csum` equals {byte 10, byte 11} of the header, with byte offsets counted from 0 at the start byte.
- R5: `res_valid` is high for exactly one cycle, the cycle after the clock edge that accepts the twentieth byte. It is low after reset.
- R6: A byte with `in_valid` and `in_sof` high starts a new header at that byte. Any partial header is discarded, and no result is produced for it.
- R7: Cycles with `in_valid` low consume no byte and do not change the sum, so gaps inside a header do not affect the result.
- R8: Bytes accepted while no header is open (no start byte seen) are ignored and produce no result.
- R9: If the last strobe arrives on a byte other than the twentieth, or the twentieth byte lacks it, the header is abandoned without a result.
- R10: A start byte may arrive in the result cycle itself. Back-to-back headers each give their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A header byte is present on `in_data` |
| in_data | input | 8 | Header byte, network order |
| in_sof | input | 1 | Byte is the first of a header |
| in_last | input | 1 | Byte is the last of a header |
| res_valid | output | 1 | One-cycle result strobe |
| res_error | output | 1 | Checksum mismatch, valid with `res_valid` |
| res_csum | output | 16 | Received checksum field, valid with `res_valid` |

## Verification
The twentieth byte is taken at one clock edge. The result state, and with it `res_valid`, `res_error` and `res_csum`, holds from that edge until the next, so the result is due exactly one cycle after the last byte is driven. The bench records the cycle number of the edge that takes each twentieth byte. A monitor samples the outputs at the falling edge and logs every pulse with its cycle, so each check compares the pulse cycle with the recorded edge as well as the values. The rules that drop a header are checked by the absence of a pulse in the cycles after the stimulus, before the next header begins.

// File: rtl/ipv4_csum_pkg.sv
package ipv4_csum_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HI     = 2'd1,
        ST_LO     = 2'd2,
        ST_REPORT = 2'd3
    } csum_state_e;
endpackage

// File: rtl/csum_word_pack.sv
module csum_word_pack
    import ipv4_csum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_msb,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word_out
);
    logic [BYTE_W-1:0] msb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q <= '0;
        end else if (ld_msb) begin
            msb_q <= byte_in;
        end
    end

    // earlier byte of the pair is the upper half
    assign word_out = {msb_q, byte_in};
endmodule

// File: rtl/csum_oc_accum.sv
module csum_oc_accum
    import ipv4_csum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W:0]   acc_raw,
    output logic [WORD_W-1:0] sum_folded
);
    logic [WORD_W:0] acc_q;
    logic [WORD_W:0] acc_next;

    // fold the previous carry in while adding the new word
    always_comb begin
        acc_next = {1'b0, acc_q[WORD_W-1:0]}
                 + {{WORD_W{1'b0}}, acc_q[WORD_W]}
                 + {1'b0, word_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (add) begin
            acc_q <= acc_next;
        end
    end

    logic [WORD_W:0] fold_wide;
    always_comb begin
        fold_wide  = {1'b0, acc_q[WORD_W-1:0]} + {{WORD_W{1'b0}}, acc_q[WORD_W]};
        sum_folded = fold_wide[WORD_W-1:0];
    end

    assign acc_raw = acc_q;
endmodule

// File: rtl/csum_field_capture.sv
module csum_field_capture
    import ipv4_csum_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int FIELD_POS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [CNT_W-1:0]  byte_idx,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] field_out
);
    localparam logic [CNT_W-1:0] LOW_IDX = CNT_W'(FIELD_POS + 1);

    logic [WORD_W-1:0] field_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
        end else if (clr) begin
            field_q <= '0;
        end else if (add && byte_idx == LOW_IDX) begin
            field_q <= word_in;
        end
    end

    assign field_out = field_q;
endmodule

// File: rtl/ipv4_csum_verifier.sv
module ipv4_csum_verifier
    import ipv4_csum_pkg::*;
#(
    parameter int HDR_BYTES = 20,
    parameter int CSUM_BYTE = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_last,
    output logic        res_valid,
    output logic        res_error,
    output logic [15:0] res_csum
);
    localparam int CNT_W = $clog2(HDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    csum_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              ld_msb, add_word, clr_acc;
    logic [WORD_W-1:0] word;
    logic [WORD_W:0]   acc_raw;
    logic [WORD_W-1:0] sum_folded;
    logic [WORD_W-1:0] field;
    logic              start;

    assign start = in_valid && in_sof;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and datapath control
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        ld_msb   = 1'b0;
        add_word = 1'b0;
        clr_acc  = 1'b0;
        if (start) begin
            // START (any state): first byte is the high half of word 0
            clr_acc = 1'b1;
            ld_msb  = 1'b1;
            cnt_d   = ONE;
            state_d = in_last ? ST_IDLE : ST_LO;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_HI: begin
                    if (in_valid) begin
                        ld_msb  = 1'b1;
                        cnt_d   = cnt_q + ONE;
                        state_d = in_last ? ST_IDLE : ST_LO;   // ABANDON / NEXT_PAIR
                    end
                end
                ST_LO: begin
                    if (in_valid) begin
                        add_word = 1'b1;
                        cnt_d    = cnt_q + ONE;
                        if (cnt_q == LAST_IDX) begin
                            state_d = in_last ? ST_REPORT : ST_IDLE; // FINISH / ABANDON
                        end else begin
                            state_d = in_last ? ST_IDLE : ST_HI;     // ABANDON / PAIR_DONE
                        end
                    end
                end
                ST_REPORT: begin
                    state_d = ST_IDLE;   // RELEASE
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        res_valid = (state_q == ST_REPORT);
        res_error = (~sum_folded) != '0;
        res_csum  = field;
    end

    csum_word_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_msb   (ld_msb),
        .byte_in  (in_data),
        .word_out (word)
    );

    csum_oc_accum u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_acc),
        .add        (add_word),
        .word_in    (word),
        .acc_raw    (acc_raw),
        .sum_folded (sum_folded)
    );

    csum_field_capture #(
        .CNT_W     (CNT_W),
        .FIELD_POS (CSUM_BYTE)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_acc),
        .add       (add_word),
        .byte_idx  (cnt_q),
        .word_in   (word),
        .field_out (field)
    );
endmodule

// File: rtl/ipv4_csum_verifier_chk.sv
module ipv4_csum_verifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_sof,
    input logic        in_last,
    input logic        res_valid,
    input logic [16:0] acc_raw
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r6_sof_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> !res_valid);

    a_r9_result_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_last));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        acc_raw != 17'h1FFFF);

    a_r7_idle_holds_sum: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_raw));
endmodule

bind ipv4_csum_verifier ipv4_csum_verifier_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_last   (in_last),
    .res_valid (res_valid),
    .acc_raw   (acc_raw)
);

// File: tb/ipv4_csum_verifier_tb_top.sv
module ipv4_csum_verifier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_sof = 1'b0;
    logic        in_last = 1'b0;
    logic        res_valid;
    logic        res_error;
    logic [15:0] res_csum;

    always #2 clk = ~clk;   // 250 MHz

    ipv4_csum_verifier dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_last(in_last), .res_valid(res_valid),
        .res_error(res_error), .res_csum(res_csum)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_acc = 0;
    int pcnt = 0;
    logic        p_err [8];
    logic [15:0] p_csum [8];
    int          p_cyc [8];
    logic [7:0]  hb [20];
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            p_err[pcnt & 7]  <= res_error;
            p_csum[pcnt & 7] <= res_csum;
            p_cyc[pcnt & 7]  <= cyc;
            pcnt <= pcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_err();
        int s = 0;
        for (int i = 0; i < 10; i++) s += {hb[2*i], hb[2*i+1]};
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >>> 16);
        return (~s[15:0]) != 16'h0000;
    endfunction

    task automatic load_vector();
        logic [15:0] w [10] = '{16'h4500, 16'h003c, 16'h1c46, 16'h4000, 16'h4017,
                                16'hc311, 16'haca8, 16'h0101, 16'haca8, 16'h0102};
        for (int i = 0; i < 10; i++) begin
            hb[2*i]   = w[i][15:8];
            hb[2*i+1] = w[i][7:0];
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] d, input logic s, input logic l);
        @(posedge clk);
        #1;
        in_valid = v; in_data = d; in_sof = s; in_last = l;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    // send hb[0..n-1]; last strobe on byte last_at (-1 for none)
    task automatic send(input int n, input bit use_sof, input int last_at, input int gap);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, hb[i], use_sof && i == 0, i == last_at);
            if (i == 19) last_acc = cyc + 1;
            if (gap > 0 && i != n - 1) idle(gap);
        end
    endtask

    task automatic expect_one(input string tag, input int p0);
        chk(pcnt == p0 + 1, {tag, " R5 pulse count"}, pcnt - p0, 1);
        chk(p_cyc[p0 & 7] == last_acc, {tag, " R5 pulse cycle"}, p_cyc[p0 & 7], last_acc);
        chk(p_err[p0 & 7] == exp_err(), {tag, " R2 error flag"}, p_err[p0 & 7], exp_err());
        chk(p_csum[p0 & 7] == {hb[10], hb[11]}, {tag, " R4 checksum field"},
            p_csum[p0 & 7], {hb[10], hb[11]});
    endtask

    task automatic t_reset();
        #1;
        chk(res_valid == 1'b0, "R5 reset", res_valid, 0);
    endtask

    task automatic t_vector();
        int p0 = pcnt;
        load_vector();
        send(20, 1, 19, 0); idle(3);
        expect_one("vector", p0);
        chk(p_err[p0 & 7] == 1'b0 && p_csum[p0 & 7] == 16'hC311, "R2 R4 known vector",
            {p_err[p0 & 7], p_csum[p0 & 7]}, 16'hC311);
    endtask

    task automatic t_corrupt();
        int p0 = pcnt;
        load_vector(); hb[3] = hb[3] ^ 8'h10;
        send(20, 1, 19, 0); idle(3);
        expect_one("corrupt", p0);
        p0 = pcnt;
        load_vector(); hb[10] = 8'h11; hb[11] = 8'hC3;
        send(20, 1, 19, 0); idle(3);
        expect_one("R1 swapped field", p0);
        chk(p_err[p0 & 7] == 1'b1, "R1 swapped bytes flagged", p_err[p0 & 7], 1);
    endtask

    task automatic t_gaps();
        int p0 = pcnt;
        load_vector();
        send(20, 1, 19, 2); idle(3);
        expect_one("R7 gaps", p0);
    endtask

    task automatic t_extremes();
        int p0 = pcnt;
        for (int i = 0; i < 20; i++) hb[i] = 8'hFF;
        send(20, 1, 19, 0); idle(3);
        expect_one("R3 all ones", p0);
        chk(p_err[p0 & 7] == 1'b0, "R3 all ones pass", p_err[p0 & 7], 0);
        p0 = pcnt;
        for (int i = 0; i < 20; i++) hb[i] = 8'h00;
        send(20, 1, 19, 0); idle(3);
        expect_one("R2 all zero", p0);
        chk(p_err[p0 & 7] == 1'b1, "R2 all zero fails", p_err[p0 & 7], 1);
    endtask

    task automatic t_restart();
        int p0 = pcnt;
        for (int i = 0; i < 20; i++) hb[i] = 8'h5A;
        send(9, 1, -1, 0);
        load_vector();
        send(20, 1, 19, 0); idle(3);
        expect_one("R6 restart", p0);
    endtask

    task automatic t_no_sof();
        int p0 = pcnt;
        load_vector();
        send(20, 0, 19, 0); idle(3);
        chk(pcnt == p0, "R8 bytes without start", pcnt - p0, 0);
    endtask

    task automatic t_bad_last();
        int p0 = pcnt;
        load_vector();
        send(20, 1, 12, 0); idle(3);
        chk(pcnt == p0, "R9 early last", pcnt - p0, 0);
        send(20, 1, -1, 0); idle(3);
        chk(pcnt == p0, "R9 missing last", pcnt - p0, 0);
    endtask

    task automatic t_back_to_back();
        int p0 = pcnt;
        int first_acc;
        load_vector();
        send(20, 1, 19, 0);
        first_acc = last_acc;
        hb[0] = 8'h46;
        send(20, 1, 19, 0); idle(3);
        chk(pcnt == p0 + 2, "R10 two pulses", pcnt - p0, 2);
        chk(p_cyc[p0 & 7] == first_acc && p_err[p0 & 7] == 1'b0, "R10 first result",
            p_cyc[p0 & 7], first_acc);
        chk(p_cyc[(p0 + 1) & 7] == last_acc && p_err[(p0 + 1) & 7] == 1'b1,
            "R10 second result", p_cyc[(p0 + 1) & 7], last_acc);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        drive(1'b0, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle(2);
        t_vector();
        t_corrupt();
        t_gaps();
        t_extremes();
        t_restart();
        t_no_sof();
        t_bad_last();
        t_back_to_back();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule